// File: doc/BRIEF.md
# Coefficient Write Strobe Qualifier

This block sits between a slow host that presents coefficient words on a level-sensitive write strobe and a coefficient load FIFO in the video clock domain. The strobe is not related to the video clock. The block passes it through a flop synchronizer. A qualification state machine then counts how many consecutive clock edges see the synchronized strobe high. When the third such edge is reached, the 32-bit data word is registered and pushed into the FIFO as a one-cycle push.

The machine re-arms only after the strobe has dropped. It also checks the minimum pulse widths: a high pulse must be held for at least six clocks, and the line must rest low for at least six clocks before the next pulse. Pulses that break the timing set a sticky protocol flag. A pulse that arrives while the FIFO reports full sets a sticky overflow flag, and its word is discarded. Each data word carries two 16-bit coefficients and passes through unchanged.

Top module: `coef_wr_capture`

## Requirements
- R1: With the strobe held high, push_o rises for one cycle in the fifth clock cycle after the first rising clock edge that samples wr_en_i high. This delay is two synchronizer stages plus the three qualifying samples.
- R2: One high pulse produces at most one push, however long the pulse lasts. push_o is never high on two consecutive cycles.
- R3: push_data_o holds the value of data_i at the capture edge, bit for bit. Bits 15:0 carry the coefficient for the newest tap and bits 31:16 carry the next coefficient.
- R4: A pulse that is sampled high on fewer than three edges produces no push and sets proto_err_o.
- R5: A pulse that is sampled high on three to five edges is still pushed, and it also sets proto_err_o.
- R6: A pulse that starts after fewer than six low samples is dropped whole and sets proto_err_o. Once that pulse ends and the line has been low for six samples, the next pulse is accepted normally.
- R7: If fifo_full_i is high on the capture edge, no push occurs, the word is discarded and ovf_err_o is set.
- R8: After reset, push_o, push_data_o, proto_err_o and ovf_err_o are all zero. Both error flags stay set until the next reset.
- R9: Traffic that meets both minimum widths (six high, six low) leaves both error flags clear and pushes every pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video processing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Asynchronous host write strobe, active high |
| data_i | input | 32 | Coefficient pair word, held stable while the strobe is high |
| fifo_full_i | input | 1 | Load FIFO full indication |
| push_o | output | 1 | One-cycle FIFO push |
| push_data_o | output | 32 | Word written on a push |
| proto_err_o | output | 1 | Sticky strobe timing violation |
| ovf_err_o | output | 1 | Sticky word-lost-on-full indication |

## Verification
A qualification counter or state that is wrong shows up at push_o within about six clocks of a strobe edge. It appears as a push at the wrong cycle, a push missing from a short pulse, or a second push during a long one. A pulse that is dropped when it should be accepted, or accepted when it should be dropped, shows up in the push count of the whole pulse train. It also shows up in proto_err_o, which changes on the edge where the bad width is detected. A fault in the capture stage shows up in push_data_o on the first push, or in ovf_err_o on the first push attempted while the FIFO is full.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // armed after reset, line assumed quiet
    ST_HIGH,  // counting qualifying high samples
    ST_HELD,  // word taken, waiting for strobe to drop
    ST_LOW,   // counting low samples since last fall
    ST_DROP   // pulse rejected, waiting for it to end
  } qual_state_e;
endpackage

// File: rtl/cwc_sync.sv
module cwc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/cwc_qual_fsm.sv
module cwc_qual_fsm
  import cwc_pkg::*;
#(
  parameter int CAPTURE_CYCLE = 3,
  parameter int MIN_HIGH      = 6,
  parameter int MIN_LOW       = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic fire_o,
  output logic proto_err_o
);
  localparam int MAX_HL  = (MIN_HIGH > MIN_LOW) ? MIN_HIGH : MIN_LOW;
  localparam int CNT_MAX = (MAX_HL > CAPTURE_CYCLE) ? MAX_HL : CAPTURE_CYCLE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] CAP_LAST = CNT_W'(CAPTURE_CYCLE - 1);
  localparam logic [CNT_W-1:0] HI_MIN   = CNT_W'(MIN_HIGH);
  localparam logic [CNT_W-1:0] LO_MIN   = CNT_W'(MIN_LOW);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  qual_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic err_q, err_set, fire;

  assign cnt_inc = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + ONE;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    err_set = 1'b0;
    fire    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en_i) begin
          state_d = ST_HIGH;
          cnt_d   = ONE;
        end
      end
      ST_HIGH: begin
        if (!en_i) begin
          err_set = 1'b1;  // fell before capture
          state_d = ST_LOW;
          cnt_d   = ONE;
        end else if (cnt_q == CAP_LAST) begin
          fire    = 1'b1;
          state_d = ST_HELD;
          cnt_d   = cnt_inc;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      ST_HELD: begin
        if (!en_i) begin
          if (cnt_q < HI_MIN) err_set = 1'b1;
          state_d = ST_LOW;
          cnt_d   = ONE;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      ST_LOW: begin
        if (en_i) begin
          if (cnt_q >= LO_MIN) begin
            state_d = ST_HIGH;
            cnt_d   = ONE;
          end else begin
            err_set = 1'b1;  // gap too short, reject whole pulse
            state_d = ST_DROP;
          end
        end else begin
          cnt_d = cnt_inc;
        end
      end
      ST_DROP: begin
        if (!en_i) begin
          state_d = ST_LOW;
          cnt_d   = ONE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_q | err_set;
    end
  end

  assign fire_o      = fire;
  assign proto_err_o = err_q;
endmodule

// File: rtl/cwc_push_stage.sv
module cwc_push_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o
);
  logic              push_q, ovf_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q <= 1'b0;
      ovf_q  <= 1'b0;
      data_q <= '0;
    end else begin
      push_q <= fire_i & ~full_i;
      if (fire_i & full_i) ovf_q <= 1'b1;
      if (fire_i & ~full_i) data_q <= data_i;
    end
  end

  assign push_o = push_q;
  assign data_o = data_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/coef_wr_capture.sv
module coef_wr_capture #(
  parameter int DATA_W        = 32,
  parameter int SYNC_STAGES   = 2,
  parameter int CAPTURE_CYCLE = 3,
  parameter int MIN_HIGH      = 6,
  parameter int MIN_LOW       = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              proto_err_o,
  output logic              ovf_err_o
);
  logic en_sync;
  logic fire;

  cwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(wr_en_i),
    .sync_o (en_sync)
  );

  cwc_qual_fsm #(
    .CAPTURE_CYCLE(CAPTURE_CYCLE),
    .MIN_HIGH     (MIN_HIGH),
    .MIN_LOW      (MIN_LOW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_sync),
    .fire_o     (fire),
    .proto_err_o(proto_err_o)
  );

  cwc_push_stage #(.DATA_W(DATA_W)) u_push (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .full_i(fifo_full_i),
    .data_i(data_i),
    .push_o(push_o),
    .data_o(push_data_o),
    .ovf_o (ovf_err_o)
  );
endmodule

// File: rtl/cwc_checks.sv
module cwc_checks #(
  parameter int SYNC_STAGES   = 2,
  parameter int CAPTURE_CYCLE = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic fifo_full_i,
  input logic push_o,
  input logic proto_err_o,
  input logic ovf_err_o
);
  assert_push_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  assert_no_push_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |=> !push_o);

  assert_proto_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o);

  generate
    if (SYNC_STAGES == 2 && CAPTURE_CYCLE == 3) begin : g_lat
      // R1: a push needs the raw strobe high on the three edges that fed it
      assert_push_needs_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_o |-> ($past(wr_en_i, 3) && $past(wr_en_i, 4) && $past(wr_en_i, 5)));
    end
  endgenerate
endmodule

bind coef_wr_capture cwc_checks #(
  .SYNC_STAGES  (SYNC_STAGES),
  .CAPTURE_CYCLE(CAPTURE_CYCLE)
) u_checks (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .fifo_full_i(fifo_full_i),
  .push_o     (push_o),
  .proto_err_o(proto_err_o),
  .ovf_err_o  (ovf_err_o)
);

// File: tb/coef_wr_capture_test.sv
`timescale 1ns/1ps
module coef_wr_capture_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        fifo_full_i = 1'b0;
  logic        push_o;
  logic [31:0] push_data_o;
  logic        proto_err_o;
  logic        ovf_err_o;

  int checks = 0;
  int errors = 0;
  int push_cnt = 0;
  logic [31:0] cur_data = '0;

  always #10 clk_i = ~clk_i;

  coef_wr_capture uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .data_i     (data_i),
    .fifo_full_i(fifo_full_i),
    .push_o     (push_o),
    .push_data_o(push_data_o),
    .proto_err_o(proto_err_o),
    .ovf_err_o  (ovf_err_o)
  );

  // fields: high A, gap, high B, full, expected pushes (incl. trailing pulse C), proto err, ovf
  localparam int NVEC = 8;
  localparam int VEC [NVEC][7] = '{
    '{ 6, 6, 6, 0, 3, 0, 0},  // R9 clean traffic
    '{ 2, 6, 6, 0, 2, 1, 0},  // R4 short pulse
    '{ 6, 5, 6, 0, 2, 1, 0},  // R6 gap too short
    '{ 3, 8, 8, 0, 3, 1, 0},  // R5 pushed but under min high
    '{ 6, 6, 6, 1, 0, 0, 1},  // R7 FIFO full
    '{40, 7, 7, 0, 3, 0, 0},  // R2 long pulse one push
    '{ 1, 6, 1, 0, 1, 1, 0},  // R4 single-cycle glitches
    '{ 5, 6, 6, 0, 3, 1, 0}   // R5 one short of min high
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor at negedge; bench drives 1 ns after posedge
  always @(negedge clk_i) begin
    if (rst_ni && push_o) begin
      push_cnt++;
      checks++;
      if (push_data_o !== cur_data) begin
        errors++;
        $display("FAIL R3: actual %h expected %h", push_data_o, cur_data);
      end
    end
  end

  task automatic do_reset();
    @(posedge clk_i); #1;
    rst_ni = 1'b0; wr_en_i = 1'b0; fifo_full_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (8) @(posedge clk_i);
    push_cnt = 0;
  endtask

  task automatic pulse(input int h, input logic [31:0] d);
    @(posedge clk_i); #1;
    data_i = d; cur_data = d; wr_en_i = 1'b1;
    repeat (h) @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic gap(input int l);
    repeat (l - 1) @(posedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8 reset state
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 push_o at reset", int'(push_o), 0);
    chk("R8 push_data_o at reset", int'(push_data_o != 0), 0);
    chk("R8 proto_err_o at reset", int'(proto_err_o), 0);
    chk("R8 ovf_err_o at reset", int'(ovf_err_o), 0);

    // R1 latency: five zero samples, then the push
    do_reset();
    @(posedge clk_i); #1;
    data_i = 32'hBEEF_1234; cur_data = data_i; wr_en_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk("R1 no early push", int'(push_o), 0);
    end
    @(negedge clk_i);
    chk("R1 push in fifth cycle", int'(push_o), 1);
    chk("R3 low coefficient", int'(push_data_o[15:0]), 16'h1234);
    chk("R3 high coefficient", int'(push_data_o[31:16]), 16'hBEEF);
    @(negedge clk_i);
    chk("R2 push lasts one cycle", int'(push_o), 0);
    @(posedge clk_i); #1 wr_en_i = 1'b0;
    repeat (8) @(posedge clk_i);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      fifo_full_i = VEC[v][3] != 0;
      pulse(VEC[v][0], 32'hA000_0000 + 32'(v));
      gap(VEC[v][1]);
      pulse(VEC[v][2], 32'hB000_0000 + 32'(v));
      gap(8);
      pulse(6, 32'hC000_0000 + 32'(v));
      repeat (10) @(posedge clk_i);
      @(negedge clk_i);
      chk($sformatf("R2/R9 push count vec %0d", v), push_cnt, VEC[v][4]);
      chk($sformatf("R4/R5/R6 proto_err vec %0d", v), int'(proto_err_o), VEC[v][5]);
      chk($sformatf("R7 ovf_err vec %0d", v), int'(ovf_err_o), VEC[v][6]);
    end

    // R7 then recovery; R8 flag stays set
    do_reset();
    fifo_full_i = 1'b1;
    pulse(6, 32'h1111_2222);
    gap(6);
    @(posedge clk_i); #1 fifo_full_i = 1'b0;
    pulse(6, 32'h3333_4444);
    repeat (8) @(posedge clk_i);
    @(negedge clk_i);
    chk("R7 only unblocked word pushed", push_cnt, 1);
    chk("R8 ovf_err stays set", int'(ovf_err_o), 1);

    // R6 dropped pulse then R8 proto_err stays set after clean traffic
    do_reset();
    pulse(6, 32'h0000_0001);
    gap(3);
    pulse(6, 32'h0000_0002);
    gap(6);
    pulse(6, 32'h0000_0003);
    gap(6);
    pulse(6, 32'h0000_0004);
    repeat (8) @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 dropped pulse not pushed", push_cnt, 3);
    chk("R8 proto_err stays set", int'(proto_err_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule